// File: doc/BRIEF.md
# Mode Request Validator with Status

This block screens requests to change the chip's operating mode before any of them is acted on. Each request names a 4-bit target mode. The block compares it with the current mode, with a per-mode enable vector and with the state of the transition sequencer. A request that passes every check starts a transition. The transition finishes after a programmable number of cycles, and the block then moves to the target mode. A request that fails any check is dropped. Each reason for the refusal is kept in its own sticky status bit, which software clears by writing 1 to it.

A small register port gives access to two registers: the sticky status register and an interrupt-enable register. Any caller may read them. A write takes effect only while the privilege input is high. Three interrupt lines come from the enabled status bits: one for refused requests, one for completed transitions and one for entry into SAFE.

Mode codes: RESET=0, SAFE=2, DRUN=3, RUN0..RUN3=4..7. Every other code is not a valid target.

Top module: `mode_req_guard`

## Requirements
- R1: A request (`req_valid`=1) that arrives while `busy`=1 sets status bit 0 (transition-illegal) at the next clock edge.
- R2: A request whose target is not a permitted destination from `cur_mode` sets status bit 1 (request-illegal). Permitted moves: SAFE to DRUN; DRUN to RUN0..RUN3 or SAFE; RUN0..RUN3 to RUN0..RUN3, DRUN or SAFE. RESET (0) and unused codes are never permitted.
- R3: A request whose target code indexes a 0 in the input `mode_enable` sets status bit 2 (disabled-mode-access).
- R4: One request can set several of bits 0..2 at once. A request that sets any of them leaves `cur_mode` unchanged and does not raise `busy`.
- R5: An accepted request raises `busy` at the next edge and holds it for `trans_len`+1 cycles. When `busy` falls, `cur_mode` equals the target and status bit 3 (transition-complete) is set. Bit 4 (SAFE-entered) is also set if the target was SAFE.
- R6: Writing `reg_sel`=0 with `reg_wdata` clears each status bit written as 1. Bits written as 0 are unchanged. If a hardware set and a clear hit the same bit in the same cycle, the bit ends up 1.
- R7: After reset, status and mask are 0, `cur_mode` is DRUN (3) and `busy` is 0. Read data bits 15..5 always read 0.
- R8: `reg_sel`=1 selects the enable register, which uses the status bit positions 0..4; 1 enables and 0 masks. `irq_invalid` is the OR of status bits 0..2 ANDed with their enables. `irq_done` is status bit 3 ANDed with enable bit 3. `irq_safe` is status bit 4 ANDed with enable bit 4. Each line stays high until the bit is cleared or masked.
- R9: A write with `priv`=0 changes neither register. Reads return data regardless of `priv`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Mode change request strobe |
| req_mode | input | 4 | Requested target mode code |
| mode_enable | input | 16 | Per-code enable, bit n enables mode code n |
| trans_len | input | 8 | Transition length parameter in cycles |
| reg_sel | input | 1 | 0 selects status, 1 selects interrupt enables |
| reg_wr | input | 1 | Register write strobe |
| priv | input | 1 | Supervisor/test privilege |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register |
| cur_mode | output | 4 | Current mode code |
| busy | output | 1 | Transition in progress |
| irq_invalid | output | 1 | Refused-request interrupt |
| irq_done | output | 1 | Transition-complete interrupt |
| irq_safe | output | 1 | SAFE-entered interrupt |

## Verification
A hardware set of a status bit and a software write-1 clear of the same bit can land on one clock edge. The bench provokes this by sending a second request during a running transition in the same cycle as a clear of bit 0, and then expects bit 0 to read 1. Separately, a request that breaks two rules at once has to set both cause bits in one cycle. The bench judges this by reading back the status word.

// File: rtl/mrg_pkg.sv
package mrg_pkg;
  localparam int MODE_W = 4;
  localparam int STAT_W = 5;

  localparam logic [MODE_W-1:0] M_RESET = 4'd0;
  localparam logic [MODE_W-1:0] M_SAFE  = 4'd2;
  localparam logic [MODE_W-1:0] M_DRUN  = 4'd3;

  localparam int B_TI   = 0;
  localparam int B_RI   = 1;
  localparam int B_DA   = 2;
  localparam int B_TC   = 3;
  localparam int B_SAFE = 4;

  function automatic logic is_run(input logic [MODE_W-1:0] m);
    return m[3:2] == 2'b01;
  endfunction

  function automatic logic move_ok(input logic [MODE_W-1:0] from_m,
                                   input logic [MODE_W-1:0] to_m);
    logic ok;
    if (from_m == M_SAFE)      ok = (to_m == M_DRUN);
    else if (from_m == M_DRUN) ok = is_run(to_m) || (to_m == M_SAFE);
    else if (is_run(from_m))   ok = is_run(to_m) || (to_m == M_DRUN) || (to_m == M_SAFE);
    else                       ok = 1'b0;
    return ok;
  endfunction
endpackage

// File: rtl/mrg_check.sv
module mrg_check
  import mrg_pkg::*;
#(
  parameter int NMODES = 16
)(
  input  logic              req_valid,
  input  logic [MODE_W-1:0] req_mode,
  input  logic [MODE_W-1:0] cur_mode,
  input  logic [NMODES-1:0] mode_enable,
  input  logic              busy,
  output logic [2:0]        viol,
  output logic              accept
);
  always_comb begin
    viol[B_TI] = req_valid && busy;
    viol[B_RI] = req_valid && !move_ok(cur_mode, req_mode);
    viol[B_DA] = req_valid && !mode_enable[req_mode];
    accept     = req_valid && (viol == 3'b000);
  end

  always_comb begin
    if (accept) a_r4_accept_clean: assert (!busy && mode_enable[req_mode]);
  end
endmodule

// File: rtl/mrg_seq.sv
module mrg_seq
  import mrg_pkg::*;
#(
  parameter int CNT_W = 8
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [MODE_W-1:0] req_mode,
  input  logic [CNT_W-1:0]  trans_len,
  output logic              busy,
  output logic [MODE_W-1:0] cur_mode,
  output logic              done,
  output logic [MODE_W-1:0] done_mode
);
  logic              busy_q, busy_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [MODE_W-1:0] tgt_q, tgt_d;
  logic [MODE_W-1:0] cur_q, cur_d;
  logic              en;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    tgt_d  = tgt_q;
    cur_d  = cur_q;
    done   = 1'b0;
    if (busy_q) begin
      if (cnt_q == '0) begin
        busy_d = 1'b0;
        cur_d  = tgt_q;
        done   = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end else if (accept) begin
      busy_d = 1'b1;
      cnt_d  = trans_len;
      tgt_d  = req_mode;
    end
    en = busy_q || accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      tgt_q  <= M_DRUN;
      cur_q  <= M_DRUN;
    end else if (en) begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      tgt_q  <= tgt_d;
      cur_q  <= cur_d;
    end
  end

  assign busy      = busy_q;
  assign cur_mode  = cur_q;
  assign done_mode = tgt_q;

  a_r5_finish: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q == '0) |=> (!busy_q && cur_q == $past(tgt_q)));
  a_r5_hold_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != '0) |=> (busy_q && $stable(cur_q)));
endmodule

// File: rtl/mrg_regs.sv
module mrg_regs
  import mrg_pkg::*;
#(
  parameter int DATA_W = 16
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] set_bits,
  input  logic              reg_sel,
  input  logic              reg_wr,
  input  logic              priv,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_invalid,
  output logic              irq_done,
  output logic              irq_safe
);
  localparam int PAD_W = DATA_W - STAT_W;

  logic [STAT_W-1:0] stat_q, stat_d, mask_q, mask_d;
  logic              wr_stat, wr_mask, stat_en;

  always_comb begin
    wr_stat = reg_wr && priv && !reg_sel;
    wr_mask = reg_wr && priv &&  reg_sel;
    stat_d  = stat_q;
    if (wr_stat) stat_d = stat_d & ~reg_wdata[STAT_W-1:0];
    stat_d  = stat_d | set_bits;
    stat_en = wr_stat || (set_bits != '0);
    mask_d  = reg_wdata[STAT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else if (stat_en) stat_q <= stat_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else if (wr_mask) mask_q <= mask_d;
  end

  always_comb begin
    reg_rdata   = {{PAD_W{1'b0}}, (reg_sel ? mask_q : stat_q)};
    irq_invalid = |(stat_q[B_DA:B_TI] & mask_q[B_DA:B_TI]);
    irq_done    = stat_q[B_TC] & mask_q[B_TC];
    irq_safe    = stat_q[B_SAFE] & mask_q[B_SAFE];
  end

  a_r1_ti_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    set_bits[B_TI] |=> stat_q[B_TI]);
  a_r6_no_silent_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stat |=> ((~stat_q & $past(stat_q)) == '0));
  a_r9_mask_guarded: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !priv) |=> $stable(mask_q));
endmodule

// File: rtl/mode_req_guard.sv
module mode_req_guard
  import mrg_pkg::*;
#(
  parameter int NMODES = 16,
  parameter int CNT_W  = 8,
  parameter int DATA_W = 16
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [3:0]        req_mode,
  input  logic [NMODES-1:0] mode_enable,
  input  logic [CNT_W-1:0]  trans_len,
  input  logic              reg_sel,
  input  logic              reg_wr,
  input  logic              priv,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [3:0]        cur_mode,
  output logic              busy,
  output logic              irq_invalid,
  output logic              irq_done,
  output logic              irq_safe
);
  logic [1:0]        rst_sync;
  logic              rst_i;
  logic [2:0]        viol;
  logic              accept, done;
  logic [MODE_W-1:0] done_mode;
  logic [STAT_W-1:0] set_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  mrg_check #(.NMODES(NMODES)) u_check (
    .req_valid(req_valid), .req_mode(req_mode), .cur_mode(cur_mode),
    .mode_enable(mode_enable), .busy(busy), .viol(viol), .accept(accept)
  );

  mrg_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_i), .accept(accept), .req_mode(req_mode),
    .trans_len(trans_len), .busy(busy), .cur_mode(cur_mode),
    .done(done), .done_mode(done_mode)
  );

  always_comb begin
    set_bits          = '0;
    set_bits[B_DA:B_TI] = viol;
    set_bits[B_TC]    = done;
    set_bits[B_SAFE]  = done && (done_mode == M_SAFE);
  end

  mrg_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_i), .set_bits(set_bits), .reg_sel(reg_sel),
    .reg_wr(reg_wr), .priv(priv), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_invalid(irq_invalid), .irq_done(irq_done), .irq_safe(irq_safe)
  );

  a_r4_reject_keeps_mode: assert property (@(posedge clk) disable iff (!rst_i)
    (req_valid && !busy && !accept) |=> (!busy && $stable(cur_mode)));
  a_r8_irq_cause: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(irq_invalid) |-> ($past(req_valid) || $past(reg_wr)));
  a_r7_upper_zero: assert property (@(posedge clk) disable iff (!rst_i)
    reg_rdata[DATA_W-1:STAT_W] == '0);
endmodule

// File: tb/mode_req_guard_test.sv
module mode_req_guard_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [3:0]  req_mode;
  logic [15:0] mode_enable;
  logic [7:0]  trans_len;
  logic        reg_sel, reg_wr, priv;
  logic [15:0] reg_wdata, reg_rdata;
  logic [3:0]  cur_mode;
  logic        busy, irq_invalid, irq_done, irq_safe;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  mode_req_guard uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .mode_enable(mode_enable), .trans_len(trans_len), .reg_sel(reg_sel),
    .reg_wr(reg_wr), .priv(priv), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cur_mode(cur_mode), .busy(busy), .irq_invalid(irq_invalid),
    .irq_done(irq_done), .irq_safe(irq_safe)
  );

  // {req_mode, mode_enable, expected status[4:0], expect accept}, from DRUN
  localparam logic [25:0] VEC [8] = '{
    {4'd4, 16'hFFFF, 5'b00000, 1'b1},  // R2 DRUN->RUN0 ok
    {4'd2, 16'hFFFF, 5'b00000, 1'b1},  // R2 DRUN->SAFE ok
    {4'd3, 16'hFFFF, 5'b00010, 1'b0},  // R2 DRUN->DRUN illegal
    {4'd0, 16'hFFFF, 5'b00010, 1'b0},  // R2 RESET never a target
    {4'd9, 16'hFFFF, 5'b00010, 1'b0},  // R2 unused code
    {4'd6, 16'hFFBF, 5'b00100, 1'b0},  // R3 RUN2 disabled
    {4'd3, 16'hFFF7, 5'b00110, 1'b0},  // R4 two causes
    {4'd7, 16'h0000, 5'b00100, 1'b0}   // R3 all disabled
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(); @(posedge clk); @(negedge clk); endtask

  task automatic do_reset();
    rst_n = 1'b0; req_valid = 1'b0; req_mode = 4'd0; mode_enable = 16'hFFFF;
    trans_len = 8'd3; reg_sel = 1'b0; reg_wr = 1'b0; priv = 1'b0; reg_wdata = '0;
    repeat (2) tick();
    rst_n = 1'b1;
    repeat (3) tick();
  endtask

  task automatic request(input logic [3:0] m);
    req_valid = 1'b1; req_mode = m; tick(); req_valid = 1'b0;
  endtask

  task automatic wr(input logic sel, input logic [15:0] d, input logic p);
    reg_sel = sel; reg_wdata = d; priv = p; reg_wr = 1'b1; tick();
    reg_wr = 1'b0; priv = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [15:0] d);
    reg_sel = sel; #1 d = reg_rdata;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    do_reset();
    // R7 reset state
    rd(1'b0, d); check("R7 status", d, 16'h0);
    rd(1'b1, d); check("R7 mask", d, 16'h0);
    check("R7 mode", {12'h0, cur_mode}, 16'h3);
    check("R7 busy", {15'h0, busy}, 16'h0);

    for (int i = 0; i < 8; i++) begin
      do_reset();
      mode_enable = VEC[i][21:6];
      request(VEC[i][25:22]);
      rd(1'b0, d); check("R2/R3/R4 vector status", d, {11'h0, VEC[i][5:1]});
      check("R4/R5 vector busy", {15'h0, busy}, {15'h0, VEC[i][0]});
      repeat (5) tick();
      check("R4/R5 vector mode", {12'h0, cur_mode},
            VEC[i][0] ? {12'h0, VEC[i][25:22]} : 16'h3);
    end

    // R5 timing with trans_len=3: busy 4 cycles, then mode and complete bit
    do_reset();
    request(4'd4);
    repeat (3) tick();
    check("R5 still busy", {15'h0, busy}, 16'h1);
    check("R5 mode held", {12'h0, cur_mode}, 16'h3);
    tick();
    check("R5 done busy", {15'h0, busy}, 16'h0);
    check("R5 done mode", {12'h0, cur_mode}, 16'h4);
    rd(1'b0, d); check("R5 tc bit", d, 16'h0008);

    // R8 irq_done with enable bit 3
    check("R8 done masked", {15'h0, irq_done}, 16'h0);
    wr(1'b1, 16'h0008, 1'b1);
    check("R8 done enabled", {15'h0, irq_done}, 16'h1);

    // R5 RUN0->SAFE sets SAFE-entered; R8 irq_safe
    wr(1'b1, 16'h0010, 1'b1);
    request(4'd2);
    repeat (4) tick();
    rd(1'b0, d); check("R5 safe bit", d, 16'h0018);
    check("R8 irq_safe", {15'h0, irq_safe}, 16'h1);

    // R2 SAFE->RUN0 illegal; R8 irq_invalid
    wr(1'b0, 16'h001F, 1'b1);
    wr(1'b1, 16'h0002, 1'b1);
    request(4'd4);
    rd(1'b0, d); check("R2 safe->run0", d, 16'h0002);
    check("R8 irq_invalid on", {15'h0, irq_invalid}, 16'h1);
    check("R4 mode kept", {12'h0, cur_mode}, 16'h2);
    wr(1'b1, 16'h0000, 1'b1);
    check("R8 irq_invalid masked", {15'h0, irq_invalid}, 16'h0);

    // R9 unprivileged writes ignored
    wr(1'b1, 16'h001F, 1'b0);
    rd(1'b1, d); check("R9 mask unchanged", d, 16'h0);
    wr(1'b0, 16'h001F, 1'b0);
    rd(1'b0, d); check("R9 status unchanged", d, 16'h0002);

    // R6 write 0 no effect, write 1 clears
    wr(1'b0, 16'h0000, 1'b1);
    rd(1'b0, d); check("R6 write0", d, 16'h0002);
    wr(1'b0, 16'h0002, 1'b1);
    rd(1'b0, d); check("R6 write1", d, 16'h0000);

    // R1 and R6 set-wins during a long transition
    do_reset();
    trans_len = 8'd6;
    request(4'd4);
    request(4'd5);
    rd(1'b0, d); check("R1 ti set", d, 16'h0001);
    req_valid = 1'b1; req_mode = 4'd5;
    reg_sel = 1'b0; reg_wdata = 16'h0001; priv = 1'b1; reg_wr = 1'b1;
    tick();
    req_valid = 1'b0; reg_wr = 1'b0; priv = 1'b0;
    rd(1'b0, d); check("R6 set wins", d, 16'h0001);
    wr(1'b0, 16'h0001, 1'b1);
    rd(1'b0, d); check("R6 clear alone", d, 16'h0000);

    // R7 upper bits read zero with all bits written
    wr(1'b1, 16'hFFFF, 1'b1);
    rd(1'b1, d); check("R7 upper zero", d, 16'h001F);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule